// File: doc/BRIEF.md
# Receive Address and Multicast Hash Filter

This block watches the receive byte stream of a 10/100 Ethernet MAC and decides, per frame, whether the frame should be kept. It captures the destination address (the first six bytes after start-of-frame) and the source address (the next six). While the destination bytes arrive it runs a reflected CRC-32 over them. After the last source byte it issues one decision strobe with an accept flag.

The decision order is fixed. Promiscuous mode accepts everything. Otherwise, when own-frame rejection is on, a frame whose source equals the station address is dropped. Otherwise a destination equal to the station address or to the broadcast address is accepted. Otherwise a multicast destination is accepted when hash filtering is on and the table bit picked by the CRC is set. All remaining frames are rejected.

Configuration goes through a small word-wide write port. Station, hash and mode settings can be changed only while the receiver is stopped. The stopped state is visible on a read-back output.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, rx_on, dec_valid and dec_accept are 0. The station words, hash words and mode bits are 0, so a multicast frame is rejected even with hash filtering enabled.
- R2: The byte taken with rx_sof is destination byte 0. Bytes 0 to 5 are the destination and bytes 6 to 11 are the source. dec_valid is high for exactly one cycle per frame, in the second cycle after the clock edge that takes byte 11. Bytes past byte 11 cause no further strobe.
- R3: A frame that ends (rx_eof) before byte 11, or that arrives while rx_on is 0, produces no strobe.
- R4: A destination equal to the station address, or equal to FF:FF:FF:FF:FF:FF, is accepted.
- R5: A unicast destination (bit 0 of byte 0 clear) that differs from the station address is rejected.
- R6: For a multicast destination (bit 0 of byte 0 set), the hash index is bits 31:26 of a CRC-32 taken over the six destination bytes. The CRC uses polynomial 0xEDB88320 in reflected form, starts from all ones, shifts in each byte LSB first, and has no final inversion. Index bits 5:4 pick the hash word and bits 3:0 pick the bit in that word. The frame is accepted only if hash filtering is on and that bit is 1.
- R7: With all four hash words at 0xFFFF and hash filtering on, every multicast destination is accepted.
- R8: In promiscuous mode every complete frame is accepted, including one that own-frame rejection would drop.
- R9: With own-frame rejection on and promiscuous mode off, a frame whose source equals the station address is rejected, even when its destination is the station or broadcast address.
- R10: Register map (cfg_addr), with 16-bit words:
  - 0 to 2: station words. In word k, bits 7:0 are address byte 2k and bits 15:8 are address byte 2k+1.
  - 4 to 7: hash words 0 to 3.
  - 8: control. Bit 0 is enable (rx_on), bit 1 is promiscuous, bit 2 is hash filtering, bit 3 is own-frame rejection.
- R11: While rx_on is 1, writes to the station and hash words are ignored, and a control write changes only the enable bit.
- R12: A frame whose byte 11 was taken before a control write that clears enable still delivers its decision, in the same cycle that rx_on falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present |
| rx_sof | input | 1 | The present byte is the first byte of a frame |
| rx_eof | input | 1 | The present byte is the last byte of a frame |
| rx_data | input | 8 | Receive byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| rx_on | output | 1 | Receiver enable read-back |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision result, meaningful with dec_valid |

## Verification
The decision strobe and a control write that stops the receiver can land on the same clock edge. The pending decision must still come out, and rx_on must fall on that same edge. The bench provokes this by issuing the stop write in the cycle right after the last source byte. It then requires one accepting strobe with rx_on already low, and requires that a following frame produces no strobe. The same sequence confirms that settings written after the stop take effect only for the next enabled frame.

// File: rtl/afl_pkg.sv
package afl_pkg;
   localparam int unsigned REG_ADDR_W = 4;
   localparam int unsigned STA_BASE   = 0;
   localparam int unsigned HASH_BASE  = 4;
   localparam int unsigned CTRL_ADDR  = 8;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   // control word bits 3:1, bit 0 is enable
   typedef struct packed {
      logic rej_own;
      logic hash_en;
      logic promisc;
   } afl_mode_t;
endpackage

// File: rtl/afl_crc_step.sv
module afl_crc_step #(
   parameter int unsigned     CRC_W = 32,
   parameter logic [CRC_W-1:0] POLY = afl_pkg::CRC_POLY_REFL
) (
   input  logic [CRC_W-1:0] c_in,
   input  logic [7:0]       d_in,
   output logic [CRC_W-1:0] c_out
);
   logic [CRC_W-1:0] stage [9];

   assign stage[0] = c_in;
   for (genvar g = 0; g < 8; g++) begin : g_bit
      assign stage[g+1] = (stage[g][0] ^ d_in[g]) ? ((stage[g] >> 1) ^ POLY)
                                                  : (stage[g] >> 1);
   end
   assign c_out = stage[8];
endmodule

// File: rtl/afl_hash_pick.sv
module afl_hash_pick #(
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned BIT_W  = $clog2(WORD_W),
   localparam int unsigned WSEL_W = IDX_W - BIT_W,
   localparam int unsigned NWORDS = 2 ** WSEL_W
) (
   input  logic [NWORDS*WORD_W-1:0] table_flat,
   input  logic [IDX_W-1:0]         idx,
   output logic                     hit
);
   logic [WORD_W-1:0] words [NWORDS];
   logic [WORD_W-1:0] sel_word;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      assign words[w] = table_flat[w*WORD_W +: WORD_W];
   end
   assign sel_word = words[idx[IDX_W-1:BIT_W]];
   assign hit      = sel_word[idx[BIT_W-1:0]];
endmodule

// File: rtl/afl_cfg_regs.sv
module afl_cfg_regs
   import afl_pkg::*;
#(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned STA_WORDS  = 3,
   parameter int unsigned HASH_WORDS = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [REG_ADDR_W-1:0]          addr,
   input  logic [WORD_W-1:0]              wdata,
   output logic                           en,
   output afl_mode_t                      mode,
   output logic [STA_WORDS*WORD_W-1:0]    sta_flat,
   output logic [HASH_WORDS*WORD_W-1:0]   hash_flat
);
   logic [WORD_W-1:0] sta_w  [STA_WORDS];
   logic [WORD_W-1:0] hash_w [HASH_WORDS];

   for (genvar w = 0; w < STA_WORDS; w++) begin : g_sta
      localparam logic [REG_ADDR_W-1:0] MY_A = REG_ADDR_W'(STA_BASE + w);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           sta_w[w] <= '0;
         else if (we && !en && addr == MY_A)   sta_w[w] <= wdata;
      end
      assign sta_flat[w*WORD_W +: WORD_W] = sta_w[w];
   end

   for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
      localparam logic [REG_ADDR_W-1:0] MY_A = REG_ADDR_W'(HASH_BASE + w);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           hash_w[w] <= '0;
         else if (we && !en && addr == MY_A)   hash_w[w] <= wdata;
      end
      assign hash_flat[w*WORD_W +: WORD_W] = hash_w[w];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         mode <= '0;
      end else if (we && addr == REG_ADDR_W'(CTRL_ADDR)) begin
         en <= wdata[0];
         if (!en) mode <= afl_mode_t'(wdata[3:1]);
      end
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import afl_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned HASH_IDX_W = 6,
   localparam int unsigned ADDR_W     = ADDR_BYTES * 8,
   localparam int unsigned STA_WORDS  = ADDR_W / WORD_W,
   localparam int unsigned HASH_BITS  = 2 ** HASH_IDX_W,
   localparam int unsigned HASH_WORDS = HASH_BITS / WORD_W,
   localparam int unsigned LAST       = 2 * ADDR_BYTES - 1,
   localparam int unsigned CNT_W      = $clog2(2 * ADDR_BYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_valid,
   input  logic                  rx_sof,
   input  logic                  rx_eof,
   input  logic [7:0]            rx_data,
   input  logic                  cfg_we,
   input  logic [REG_ADDR_W-1:0] cfg_addr,
   input  logic [WORD_W-1:0]     cfg_wdata,
   output logic                  rx_on,
   output logic                  dec_valid,
   output logic                  dec_accept
);
   if ((ADDR_W % WORD_W) != 0) begin : g_bad_sta
      $error("address width must be a whole number of config words");
   end
   if ((HASH_BITS % WORD_W) != 0 || HASH_WORDS > 4 || STA_WORDS > 4) begin : g_bad_map
      $error("hash table or station words do not fit the register map");
   end
   if (HASH_IDX_W > 32 || HASH_IDX_W <= $clog2(WORD_W)) begin : g_bad_idx
      $error("hash index width out of range");
   end

   logic                         en;
   afl_mode_t                    mode;
   logic [ADDR_W-1:0]            sta_flat;
   logic [HASH_BITS-1:0]         hash_flat;
   logic [ADDR_W-1:0]            dst_flat, src_flat;
   logic [31:0]                  crc_q, crc_src, crc_nx;
   logic [CNT_W-1:0]             cnt, byte_ix;
   logic                         in_frame, pend, take, hash_hit, verdict;

   afl_cfg_regs #(.WORD_W(WORD_W), .STA_WORDS(STA_WORDS), .HASH_WORDS(HASH_WORDS)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .en(en), .mode(mode), .sta_flat(sta_flat), .hash_flat(hash_flat)
   );

   assign rx_on   = en;
   assign take    = en && rx_valid && (rx_sof || in_frame);
   assign byte_ix = rx_sof ? '0 : cnt;
   assign crc_src = rx_sof ? '1 : crc_q;

   afl_crc_step #(.CRC_W(32), .POLY(CRC_POLY_REFL)) u_crc (
      .c_in(crc_src), .d_in(rx_data), .c_out(crc_nx)
   );

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dst_flat[b*8 +: 8] <= '0;
            src_flat[b*8 +: 8] <= '0;
         end else if (take) begin
            if (byte_ix == CNT_W'(b))              dst_flat[b*8 +: 8] <= rx_data;
            if (byte_ix == CNT_W'(ADDR_BYTES + b)) src_flat[b*8 +: 8] <= rx_data;
         end
      end
   end

   afl_hash_pick #(.IDX_W(HASH_IDX_W), .WORD_W(WORD_W)) u_pick (
      .table_flat(hash_flat), .idx(crc_q[31 -: HASH_IDX_W]), .hit(hash_hit)
   );

   always_comb begin
      if (mode.promisc)                                  verdict = 1'b1;
      else if (mode.rej_own && src_flat == sta_flat)     verdict = 1'b0;
      else if (dst_flat == sta_flat || &dst_flat)        verdict = 1'b1;
      else verdict = dst_flat[0] && mode.hash_en && hash_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q      <= '1;
         cnt        <= '0;
         in_frame   <= 1'b0;
         pend       <= 1'b0;
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= pend;
         dec_accept <= pend && verdict;
         pend       <= take && byte_ix == CNT_W'(LAST);
         if (take && byte_ix < CNT_W'(ADDR_BYTES)) crc_q <= crc_nx;
         if (!en) begin
            in_frame <= 1'b0;
         end else if (take) begin
            cnt      <= byte_ix + 1'b1;
            in_frame <= !rx_eof && byte_ix != CNT_W'(LAST);
         end
      end
   end
endmodule

// File: rtl/afl_chk.sv
module afl_chk #(
   parameter int unsigned ADDR_W    = 48,
   parameter int unsigned HASH_BITS = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 dec_valid,
   input logic                 dec_accept,
   input logic                 pend,
   input logic                 en,
   input logic                 promisc,
   input logic                 rej_own,
   input logic [ADDR_W-1:0]    sta_flat,
   input logic [ADDR_W-1:0]    dst_flat,
   input logic [ADDR_W-1:0]    src_flat,
   input logic [HASH_BITS-1:0] hash_flat
);
   // R2
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !pend) |=> !dec_valid);

   // R8
   promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && promisc) |-> dec_accept);

   // R9
   own_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !promisc && rej_own && src_flat == sta_flat) |-> !dec_accept);

   // R4
   bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !(rej_own && src_flat == sta_flat) && &dst_flat) |-> dec_accept);

   // R11
   locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($stable(sta_flat) && $stable(hash_flat)));
endmodule

bind rx_addr_filter afl_chk #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_accept(dec_accept),
   .pend(pend), .en(en), .promisc(mode.promisc), .rej_own(mode.rej_own),
   .sta_flat(sta_flat), .dst_flat(dst_flat), .src_flat(src_flat), .hash_flat(hash_flat)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
   localparam int PERIOD = 10;
   localparam logic [47:0] STA   = 48'h0A0B_0C0D_0E10;
   localparam logic [47:0] STA2  = 48'h0A0B_0C0D_7720;
   localparam logic [47:0] OTH   = 48'h1122_3344_5566;
   localparam logic [47:0] OTH2  = 48'h99AA_BBCC_DD02;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] M1    = 48'h6655_4433_2201;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
   logic [7:0] rx_data = '0;
   logic cfg_we = 0;
   logic [3:0] cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic rx_on, dec_valid, dec_accept;

   int checks = 0, errors = 0, sc = 0;
   logic sa = 1'b0;
   logic [47:0] m2;

   always #(PERIOD/2) clk = ~clk;

   rx_addr_filter u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_data(rx_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .rx_on(rx_on), .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   always @(negedge clk) if (dec_valid) begin sc = sc + 1; sa = dec_accept; end

   function automatic logic [5:0] hidx(input logic [47:0] a);
      logic [31:0] c = '1;
      for (int b = 0; b < 48; b++) begin
         if (c[0] ^ a[b]) c = (c >> 1) ^ 32'hEDB8_8320;
         else             c = c >> 1;
      end
      return c[31:26];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic set_sta(input logic [47:0] s);
      for (int k = 0; k < 3; k++) wr(4'(k), s[16*k +: 16]);
   endtask

   task automatic send(input logic [47:0] d, input logic [47:0] s, input int n,
                       input bit kill, input int exp_n, input bit exp_acc, input string req);
      @(posedge clk); sc = 0;
      for (int b = 0; b < n; b++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = (b == 0); rx_eof = (b == n - 1);
         rx_data = (b < 6) ? d[8*b +: 8] : (b < 12) ? s[8*(b-6) +: 8] : 8'(b);
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0;
      if (kill) begin cfg_we = 1; cfg_addr = 4'd8; cfg_wdata = 16'h0; end
      if (n == 12 && exp_n == 1) chk(dec_valid == 0, {req, " strobe early"}, dec_valid, 0);
      @(negedge clk);
      cfg_we = 0;
      if (n == 12 && exp_n == 1) chk(dec_valid == 1, {req, " strobe timing"}, dec_valid, 1);
      if (kill) chk(rx_on == 0, "R12 rx_on falls with strobe", rx_on, 0);
      repeat (3) @(negedge clk);
      #1;
      chk(sc == exp_n, {req, " strobe count"}, sc, exp_n);
      if (exp_n == 1) chk(sa == exp_acc, {req, " accept"}, sa, exp_acc);
   endtask

   task automatic t_reset;
      #1;
      chk(rx_on == 0 && dec_valid == 0 && dec_accept == 0, "R1 reset outputs",
          {rx_on, dec_valid, dec_accept}, 0);
      send(STA, OTH, 12, 0, 0, 0, "R3 disabled frame");
   endtask

   task automatic t_unicast;
      set_sta(STA);
      wr(4'd8, 16'h1);
      send(STA, OTH, 12, 0, 1, 1, "R4 station dest");
      send(OTH2, OTH, 12, 0, 1, 0, "R5 other unicast");
      send(BCAST, OTH, 12, 0, 1, 1, "R4 broadcast");
      send(STA, OTH, 20, 0, 1, 1, "R2 long frame one strobe");
      send(STA, OTH, 9, 0, 0, 0, "R3 short frame");
   endtask

   task automatic t_hash;
      logic [5:0] ix;
      wr(4'd8, 16'h0); wr(4'd8, 16'h5);
      send(M1, OTH, 12, 0, 1, 0, "R1 hash cleared");
      ix = hidx(M1);
      wr(4'd8, 16'h0);
      wr(4'(4 + ix[5:4]), 16'(1) << ix[3:0]);
      wr(4'd8, 16'h5);
      send(M1, OTH, 12, 0, 1, 1, "R6 hash bit set");
      send(m2, OTH, 12, 0, 1, 0, "R6 hash bit clear");
      wr(4'd8, 16'h0); wr(4'd8, 16'h1);
      send(M1, OTH, 12, 0, 1, 0, "R6 hash disabled");
   endtask

   task automatic t_allmulti;
      wr(4'd8, 16'h0);
      for (int k = 0; k < 4; k++) wr(4'(4 + k), 16'hFFFF);
      wr(4'd8, 16'h5);
      send(m2, OTH, 12, 0, 1, 1, "R7 all-multicast m2");
      send(M1 ^ 48'h0000_0000_F000, OTH, 12, 0, 1, 1, "R7 all-multicast m3");
   endtask

   task automatic t_own;
      wr(4'd8, 16'h0); wr(4'd8, 16'h9);
      send(BCAST, STA, 12, 0, 1, 0, "R9 own source broadcast");
      send(STA, STA, 12, 0, 1, 0, "R9 own source station");
      send(STA, OTH, 12, 0, 1, 1, "R9 foreign source");
   endtask

   task automatic t_promisc;
      wr(4'd8, 16'h0); wr(4'd8, 16'hB);
      send(OTH2, STA, 12, 0, 1, 1, "R8 promisc over own reject");
      send(OTH, OTH2, 12, 0, 1, 1, "R8 promisc unicast");
   endtask

   task automatic t_lock;
      wr(4'd8, 16'h0); wr(4'd8, 16'h1);
      wr(4'd0, STA2[15:0]);
      wr(4'd8, 16'h3);
      send(STA, OTH, 12, 0, 1, 1, "R11 station write ignored");
      send(OTH2, OTH, 12, 0, 1, 0, "R11 mode write ignored");
      wr(4'd8, 16'h0);
      wr(4'd0, STA2[15:0]);
      wr(4'd8, 16'h1);
      send(STA2, OTH, 12, 0, 1, 1, "R10 station word 0 bytes");
      send(STA, OTH, 12, 0, 1, 0, "R10 old station rejected");
   endtask

   task automatic t_collide;
      send(STA2, OTH, 12, 1, 1, 1, "R12 stop on strobe edge");
      send(STA2, OTH, 12, 0, 0, 0, "R12 stopped after");
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m2 = M1;
      for (int k = 1; k < 256 && hidx(m2) == hidx(M1); k++) m2[15:8] = 8'(k);
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset;
      t_unicast;
      t_hash;
      t_allmulti;
      t_own;
      t_promisc;
      t_lock;
      t_collide;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule